// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Unit

This block steers operands and pipeline control for a single-issue, in-order, five-stage integer pipeline. For each of the two source operands of the instruction in execute, it picks where the operand comes from: the register file, the result waiting in the execute/memory register, or the result waiting in the memory/writeback register. When several producers write the same register, the youngest one wins. Dependent ALU instructions therefore run back to back with no lost cycle.

A load followed directly by an instruction that reads the loaded register cannot be served by forwarding. For that case the block freezes the program counter and the fetch/decode register for one clock and puts a bubble into the decode/execute register. On the next cycle the loaded value reaches the memory/writeback register and is forwarded from there.

Two redirect causes come from branch resolution. The first is a taken branch that had no early target at fetch. The second is a misprediction. Either one flushes the fetch/decode and decode/execute registers to NOPs with their write enables cleared. A flush takes precedence over a stall in the same cycle.

Top module: `hazard_unit`

## Requirements
- R1: An operand select is 2'b01 (execute/memory result) when `mem_we` is 1, `mem_rd` is nonzero and `mem_rd` equals that operand's source register.
- R2: An operand select is 2'b10 (memory/writeback result) when `wb_we` is 1, `wb_rd` is nonzero, `wb_rd` equals the source register, and the R1 condition does not hold. When both producers match, the select is 2'b01.
- R3: In all other cases an operand select is 2'b00 (register file). A source register of 0 always yields 2'b00. The value 2'b11 never appears.
- R4: A load in execute (`ex_is_load`=1, `ex_we`=1, nonzero `ex_rd`) whose `ex_rd` equals `id_rs1` or `id_rs2` raises `pc_hold`, `ifid_hold` and `idex_bubble` together in that same cycle.
- R5: There is no stall when `ex_rd` is 0, when `ex_is_load` is 0, when `ex_we` is 0, or when neither decode source matches.
- R6: A stall lasts exactly one cycle. In the cycle after a stall, the three stall outputs are 0 even if the load-use inputs are still present.
- R7: When `redirect_nopred` or `redirect_mispredict` is 1, both `ifid_flush` and `idex_flush` are 1 in that cycle.
- R8: A flush overrides a stall. When a redirect and a load-use hit occur together, the stall outputs are 0. Because no stall was taken, a load-use hit in the next cycle stalls.
- R9: While `rst` is high, `pc_hold`, `ifid_hold`, `idex_bubble`, `ifid_flush` and `idex_flush` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | REG_AW | Source register 1 of the instruction in decode |
| id_rs2 | input | REG_AW | Source register 2 of the instruction in decode |
| ex_rs1 | input | REG_AW | Source register 1 of the instruction in execute |
| ex_rs2 | input | REG_AW | Source register 2 of the instruction in execute |
| ex_rd | input | REG_AW | Destination register of the instruction in execute |
| ex_we | input | 1 | Write enable of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_AW | Destination register in execute/memory register |
| mem_we | input | 1 | Write enable in execute/memory register |
| wb_rd | input | REG_AW | Destination register in memory/writeback register |
| wb_we | input | 1 | Write enable in memory/writeback register |
| redirect_nopred | input | 1 | Taken branch resolved with no early target at fetch |
| redirect_mispredict | input | 1 | Resolved branch disagrees with its fetch prediction |
| fwd_a_sel | output | 2 | Operand 1 source select |
| fwd_b_sel | output | 2 | Operand 2 source select |
| pc_hold | output | 1 | Freeze program counter |
| ifid_hold | output | 1 | Freeze fetch/decode register |
| idex_bubble | output | 1 | Insert NOP into decode/execute register |
| ifid_flush | output | 1 | Clear fetch/decode register to NOP |
| idex_flush | output | 1 | Clear decode/execute register to NOP |

## Verification
The bench builds the block with the default parameters: 5-bit register numbers and two source operands. With these values, register 0 and register 31 can be driven directly, so both ends of the register range and the register-0 exception are tested. The same register numbers also let one producer match both operands at once, which exercises the youngest-wins priority on each select. Repeating a load-use hit over several cycles brings the alternating stall pattern and its interaction with a redirect within reach.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_EXMEM = 2'b01,
    FWD_MEMWB = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  output fwd_sel_e          sel
);
  logic src_live;
  logic hit_mem;
  logic hit_wb;

  assign src_live = (src != '0);
  assign hit_mem  = src_live && mem_we && (mem_rd == src);
  assign hit_wb   = src_live && wb_we  && (wb_rd  == src);

  // youngest producer first
  always_comb begin
    if (hit_mem)     sel = FWD_EXMEM;
    else if (hit_wb) sel = FWD_MEMWB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
  input  logic [REG_AW-1:0]              ex_rd,
  input  logic                           ex_we,
  input  logic                           ex_is_load,
  input  logic                           flush,
  output logic                           stall
);
  logic [NUM_SRC-1:0] src_hit;
  logic               load_live;
  logic               stall_q;

  assign load_live = ex_is_load && ex_we && (ex_rd != '0);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_match
    assign src_hit[i] = load_live && (id_src[i] == ex_rd);
  end

  assign stall = (|src_hit) && !stall_q && !flush && !rst;

  always_ff @(posedge clk) begin
    if (rst) stall_q <= 1'b0;
    else     stall_q <= stall;
  end

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall); // R6
  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ex_is_load && ex_we && ex_rd != '0)); // R5
endmodule

// File: rtl/hzd_flush_ctl.sv
module hzd_flush_ctl (
  input  logic clk,
  input  logic rst,
  input  logic redirect_nopred,
  input  logic redirect_mispredict,
  output logic flush_any,
  output logic ifid_flush,
  output logic idex_flush
);
  assign flush_any  = !rst && (redirect_nopred || redirect_mispredict);
  assign ifid_flush = flush_any;
  assign idex_flush = flush_any;

  AST_FLUSH_ON_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    (redirect_nopred || redirect_mispredict) |-> (ifid_flush && idex_flush)); // R7
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_we,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  input  logic              redirect_nopred,
  input  logic              redirect_mispredict,
  output logic [1:0]        fwd_a_sel,
  output logic [1:0]        fwd_b_sel,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              idex_bubble,
  output logic              ifid_flush,
  output logic              idex_flush
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_AW-1:0] ex_src;
  logic [NUM_SRC-1:0][REG_AW-1:0] id_src;
  fwd_sel_e                       sel [NUM_SRC];
  logic                           flush_any;
  logic                           stall;

  assign ex_src = {ex_rs2, ex_rs1};
  assign id_src = {id_rs2, id_rs1};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_fwd
    hzd_fwd_sel #(.REG_AW(REG_AW)) u_fwd (
      .src    (ex_src[i]),
      .mem_rd (mem_rd),
      .mem_we (mem_we),
      .wb_rd  (wb_rd),
      .wb_we  (wb_we),
      .sel    (sel[i])
    );
  end

  assign fwd_a_sel = sel[0];
  assign fwd_b_sel = sel[1];

  hzd_flush_ctl u_flush (
    .clk                 (clk),
    .rst                 (rst),
    .redirect_nopred     (redirect_nopred),
    .redirect_mispredict (redirect_mispredict),
    .flush_any           (flush_any),
    .ifid_flush          (ifid_flush),
    .idex_flush          (idex_flush)
  );

  hzd_load_use #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_lu (
    .clk        (clk),
    .rst        (rst),
    .id_src     (id_src),
    .ex_rd      (ex_rd),
    .ex_we      (ex_we),
    .ex_is_load (ex_is_load),
    .flush      (flush_any),
    .stall      (stall)
  );

  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;

  AST_X0_NOT_FORWARDED: assert property (@(posedge clk) disable iff (rst)
    (ex_rs1 == '0) |-> (fwd_a_sel == 2'b00)); // R3
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11)); // R3
  AST_YOUNGEST_WINS: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_rd != '0 && mem_rd == ex_rs2) |-> (fwd_b_sel == 2'b01)); // R2
  AST_FLUSH_OVER_STALL: assert property (@(posedge clk) disable iff (rst)
    ifid_flush |-> (!pc_hold && !ifid_hold && !idex_bubble)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> !(pc_hold || ifid_hold || idex_bubble || ifid_flush || idex_flush)); // R9
endmodule

// File: tb/tb_hazard_unit.sv
module tb_hazard_unit;
  localparam int REG_AW = 5;
  localparam int NVEC   = 8;

  logic clk = 1'b0;
  logic rst;
  logic [REG_AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_we, ex_is_load, mem_we, wb_we, redirect_nopred, redirect_mispredict;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hazard_unit #(.REG_AW(REG_AW)) dut (.*);

  // {ex_rs1, ex_rs2, mem_rd, mem_we, wb_rd, wb_we, exp_a, exp_b}
  localparam logic [25:0] VEC [NVEC] = '{
    {5'd3,  5'd4,  5'd3,  1'b1, 5'd4,  1'b1, 2'b01, 2'b10},
    {5'd5,  5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 2'b01, 2'b01},
    {5'd6,  5'd7,  5'd6,  1'b0, 5'd6,  1'b1, 2'b10, 2'b00},
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00},
    {5'd8,  5'd9,  5'd10, 1'b1, 5'd11, 1'b1, 2'b00, 2'b00},
    {5'd12, 5'd12, 5'd13, 1'b1, 5'd12, 1'b0, 2'b00, 2'b00},
    {5'd31, 5'd2,  5'd2,  1'b1, 5'd31, 1'b1, 2'b10, 2'b01},
    {5'd1,  5'd1,  5'd1,  1'b0, 5'd1,  1'b0, 2'b00, 2'b00}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    id_rs1 = '0; id_rs2 = '0; ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0;
    mem_rd = '0; wb_rd = '0; ex_we = 0; ex_is_load = 0; mem_we = 0;
    wb_we = 0; redirect_nopred = 0; redirect_mispredict = 0;
  endtask

  task automatic load_use(input logic [REG_AW-1:0] rd, input logic [REG_AW-1:0] r1,
                          input logic [REG_AW-1:0] r2);
    ex_is_load = 1; ex_we = 1; ex_rd = rd; id_rs1 = r1; id_rs2 = r2;
  endtask

  // drive 1 ns after a rising edge, sample 1 ns later
  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [3:0] stall3();
    return {1'b0, pc_hold, ifid_hold, idex_bubble};
  endfunction

  initial begin
    quiet();
    rst = 1;
    load_use(5'd4, 5'd4, 5'd0);
    redirect_mispredict = 1;
    step(); #1;
    chk("R9 reset stall", stall3(), 4'h0);
    chk("R9 reset flush", {2'b0, ifid_flush, idex_flush}, 4'h0);
    quiet();
    step(); rst = 0;
    step(); #1;
    chk("R9 idle after reset", {stall3()[2:0], ifid_flush}, 4'h0);

    for (int i = 0; i < NVEC; i++) begin
      step();
      {ex_rs1, ex_rs2, mem_rd, mem_we, wb_rd, wb_we} = VEC[i][25:4];
      #1;
      chk($sformatf("R1/R2/R3 vec%0d opA", i), {2'b0, fwd_a_sel}, {2'b0, VEC[i][3:2]});
      chk($sformatf("R1/R2/R3 vec%0d opB", i), {2'b0, fwd_b_sel}, {2'b0, VEC[i][1:0]});
    end
    quiet();

    // R4 stall on rs2 match, then R6 one-cycle
    step(); load_use(5'd9, 5'd3, 5'd9); #1;
    chk("R4 stall on rs2", stall3(), 4'h7);
    step(); #1;
    chk("R6 no second stall", stall3(), 4'h0);
    step(); #1;
    chk("R6 stall again after gap", stall3(), 4'h7);
    step(); quiet(); #1;

    // R5 non-stall cases
    step(); load_use(5'd0, 5'd0, 5'd0); #1;
    chk("R5 x0 load", stall3(), 4'h0);
    step(); load_use(5'd7, 5'd7, 5'd1); ex_is_load = 0; #1;
    chk("R5 not a load", stall3(), 4'h0);
    step(); load_use(5'd7, 5'd7, 5'd1); ex_we = 0; #1;
    chk("R5 no write", stall3(), 4'h0);
    step(); load_use(5'd7, 5'd6, 5'd5); #1;
    chk("R5 no match", stall3(), 4'h0);
    step(); quiet(); #1;

    // R7 both causes
    step(); redirect_nopred = 1; #1;
    chk("R7 nopred flush", {2'b0, ifid_flush, idex_flush}, 4'h3);
    step(); redirect_nopred = 0; redirect_mispredict = 1; #1;
    chk("R7 mispredict flush", {2'b0, ifid_flush, idex_flush}, 4'h3);
    step(); redirect_mispredict = 0; #1;
    chk("R7 no redirect", {2'b0, ifid_flush, idex_flush}, 4'h0);

    // R8 flush over stall, stall allowed next cycle
    step(); load_use(5'd12, 5'd12, 5'd0); redirect_mispredict = 1; #1;
    chk("R8 stall masked by flush", stall3(), 4'h0);
    chk("R8 flush still raised", {2'b0, ifid_flush, idex_flush}, 4'h3);
    step(); redirect_mispredict = 0; #1;
    chk("R8 stall after flush", stall3(), 4'h7);
    step(); quiet(); #1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule